// File: doc/BRIEF.md
# Cache Parity Error Recovery Controller

This block sits next to the lookup path of a level-one cache. Every word read out of the cache data array arrives with one even-parity bit per byte. A 3-bit policy field chooses whether parity is checked and, if it is, whether a detected error is also reported as an abort. Recovery cannot be switched off while checking is on. When an error is found, the controller invalidates the faulty line, then asks the next memory level to refetch it. It records the line address in a fault-location register and pulses an event output. Software can therefore follow errors without aborts.

Correction works by discarding a line and reading it again, so no line may hold the only copy of modified data. While checking is enabled, the controller therefore turns the write-back attribute of every allocation into write-through. During a recovery it raises a hold output so that the lookup path issues no further reads for checking until the refetch has been accepted.

Top module: `cache_parity_ctrl`

## Requirements
- R1: With mode_i = 3'b000, a read with a parity error produces a one-cycle abort_o pulse together with event_o, and the recovery sequence also runs.
- R2: With mode_i = 3'b101, a read with a parity error produces event_o and the recovery sequence, and abort_o stays low.
- R3: With mode_i = 3'b100 or any reserved value (001, 010, 011, 110, 111), no read raises event_o or abort_o, starts a recovery, or changes fault_addr_o.
- R4: Parity is even per byte. Bit b of rd_par_i covers rd_data_i[8b+7:8b], and the XOR of that byte with its parity bit must be 0. A mismatch in any one or more bytes flags the whole access, and a read with all bytes correct flags nothing.
- R5: mem_wb_o equals mem_wb_i when checking is disabled, and is 0 when mode_i is 3'b000 or 3'b101.
- R6: event_o and abort_o are single-cycle pulses. They are registered and rise in the cycle after the edge that samples the faulty read.
- R7: fault_addr_o is loaded with rd_addr_i of each detected faulty read, and it is visible in the same cycle as event_o. It keeps its value across clean reads.
- R8: inval_req_o rises in the cycle after a detected error, with recov_addr_o holding the faulty read address. Both stay unchanged until inval_ack_i is sampled high.
- R9: refill_req_o rises only in the cycle after inval_ack_i has been accepted, and never together with inval_req_o. It carries the same recov_addr_o and is held until refill_ack_i is sampled high.
- R10: hold_o is high from the cycle after a detected error until the edge that accepts refill_ack_i. A read presented while hold_o is high is not checked.
- R11: After reset, event_o, abort_o, inval_req_o, refill_req_o and hold_o are 0, and fault_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Parity policy field |
| rd_valid_i | input | 1 | A cache data read is presented this cycle |
| rd_data_i | input | DATA_W | Read data from the cache array |
| rd_par_i | input | DATA_W/8 | Stored even-parity bit per byte |
| rd_addr_i | input | ADDR_W | Line address of the read |
| mem_wb_i | input | 1 | Allocation requested with write-back write-allocate attribute |
| mem_wb_o | output | 1 | Effective write-back attribute after policy |
| event_o | output | 1 | Error-detected event pulse |
| abort_o | output | 1 | Abort pulse |
| fault_addr_o | output | ADDR_W | Last faulting line address |
| hold_o | output | 1 | Recovery in progress; lookup path must stall |
| inval_req_o | output | 1 | Line invalidate request |
| inval_ack_i | input | 1 | Invalidate accepted |
| refill_req_o | output | 1 | Refetch request to next level |
| refill_ack_i | input | 1 | Refetch accepted |
| recov_addr_o | output | ADDR_W | Line address under recovery |

## Verification
The hardest situation to reach is a second faulty read that arrives while a recovery is still waiting on its handshakes. It must not produce an event, a new fault address or a restart of the sequence. The bench gets there by keeping inval_ack_i low after an error and driving a corrupted read while hold_o is high. It then checks that event_o and fault_addr_o are unchanged before it completes the handshakes. Slow acknowledges held over several cycles also show that the requests and their address stay stable.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam logic [2:0] MODE_CHK_ABORT  = 3'b000;
  localparam logic [2:0] MODE_CHK_SILENT = 3'b101;

  typedef struct packed {
    logic chk_en;
    logic abort_en;
  } policy_t;

  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_INVAL  = 2'd1,
    RS_REFILL = 2'd2
  } rec_state_e;
endpackage

// File: rtl/cpr_mode_decode.sv
module cpr_mode_decode
  import cpr_pkg::*;
(
  input  logic [2:0] mode_i,
  output policy_t    policy_o
);
  // reserved values fall through to disabled
  always_comb begin
    policy_o = '0;
    unique case (mode_i)
      MODE_CHK_ABORT:  policy_o = '{chk_en: 1'b1, abort_en: 1'b1};
      MODE_CHK_SILENT: policy_o = '{chk_en: 1'b1, abort_en: 1'b0};
      default:         policy_o = '0;
    endcase
  end
endmodule

// File: rtl/cpr_parity_check.sv
module cpr_parity_check #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   data_i,
  input  logic [DATA_W/8-1:0] par_i,
  output logic [DATA_W/8-1:0] byte_err_o,
  output logic                err_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_err_o[b] = ^{data_i[8*b +: 8], par_i[b]};
  end

  assign err_o = |byte_err_o;
endmodule

// File: rtl/cpr_recovery_fsm.sv
module cpr_recovery_fsm
  import cpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inval_ack_i,
  input  logic              refill_ack_i,
  output logic              inval_req_o,
  output logic              refill_req_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  rec_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:   if (start_i)      state_d = RS_INVAL;
      RS_INVAL:  if (inval_ack_i)  state_d = RS_REFILL;
      RS_REFILL: if (refill_ack_i) state_d = RS_IDLE;
      default:                     state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == RS_IDLE && start_i) addr_q <= addr_i;
    end
  end

  assign inval_req_o  = (state_q == RS_INVAL);
  assign refill_req_o = (state_q == RS_REFILL);
  assign busy_o       = (state_q != RS_IDLE);
  assign addr_o       = addr_q;
endmodule

// File: rtl/cache_parity_ctrl.sv
module cache_parity_ctrl
  import cpr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic                rd_valid_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic [DATA_W/8-1:0] rd_par_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                mem_wb_i,
  output logic                mem_wb_o,
  output logic                event_o,
  output logic                abort_o,
  output logic [ADDR_W-1:0]   fault_addr_o,
  output logic                hold_o,
  output logic                inval_req_o,
  input  logic                inval_ack_i,
  output logic                refill_req_o,
  input  logic                refill_ack_i,
  output logic [ADDR_W-1:0]   recov_addr_o
);
  localparam int unsigned NBYTES = DATA_W / 8;

  policy_t           policy;
  logic [NBYTES-1:0] byte_err;
  logic              par_err;
  logic              busy;
  logic              hit_err;
  logic              event_q, abort_q;
  logic [ADDR_W-1:0] fault_q;

  cpr_mode_decode i_mode (
    .mode_i   (mode_i),
    .policy_o (policy)
  );

  cpr_parity_check #(.DATA_W(DATA_W)) i_par (
    .data_i     (rd_data_i),
    .par_i      (rd_par_i),
    .byte_err_o (byte_err),
    .err_o      (par_err)
  );

  // reads during a recovery are not checked
  assign hit_err = rd_valid_i && !busy && policy.chk_en && par_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      event_q <= 1'b0;
      abort_q <= 1'b0;
      fault_q <= '0;
    end else begin
      event_q <= hit_err;
      abort_q <= hit_err && policy.abort_en;
      if (hit_err) fault_q <= rd_addr_i;
    end
  end

  cpr_recovery_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (hit_err),
    .addr_i       (rd_addr_i),
    .inval_ack_i  (inval_ack_i),
    .refill_ack_i (refill_ack_i),
    .inval_req_o  (inval_req_o),
    .refill_req_o (refill_req_o),
    .busy_o       (busy),
    .addr_o       (recov_addr_o)
  );

  // lines must never be dirty while checking is on
  assign mem_wb_o     = mem_wb_i && !policy.chk_en;
  assign event_o      = event_q;
  assign abort_o      = abort_q;
  assign fault_addr_o = fault_q;
  assign hold_o       = busy;
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic              rd_valid_i,
  input logic              mem_wb_o,
  input logic              event_o,
  input logic              abort_o,
  input logic              hold_o,
  input logic              inval_req_o,
  input logic              inval_ack_i,
  input logic              refill_req_o,
  input logic [ADDR_W-1:0] recov_addr_o
);
  logic chk_mode;
  assign chk_mode = (mode_i == 3'b000) || (mode_i == 3'b101);

  p_abort_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> event_o && $past(mode_i) == 3'b000);

  p_silent_no_abort_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && !hold_o && mode_i == 3'b101 |=> !abort_o);

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i && !chk_mode |=> !event_o && !hold_o);

  p_wt_forced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_mode |-> !mem_wb_o);

  p_event_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);

  p_inval_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_req_o && !inval_ack_i |=> inval_req_o && $stable(recov_addr_o));

  p_refill_after_inval_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refill_req_o) |-> $past(inval_req_o && inval_ack_i));

  p_req_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inval_req_o && refill_req_o));

  p_event_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> hold_o && inval_req_o);
endmodule

bind cache_parity_ctrl cpr_checker #(.ADDR_W(ADDR_W)) i_cpr_checker (.*);

// File: tb/test_cache_parity_ctrl.sv
module test_cache_parity_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NB = DATA_W / 8;
  localparam int unsigned NVEC = 12;

  // {mode, data, corrupt byte mask, addr}
  localparam logic [50:0] VEC [NVEC] = '{
    {3'b000, 32'hA5A5_0001, 4'b0000, 12'h011},
    {3'b000, 32'h1234_5678, 4'b0001, 12'h122},
    {3'b101, 32'hDEAD_BEEF, 4'b0100, 12'h233},
    {3'b100, 32'hFFFF_0000, 4'b1111, 12'h344},
    {3'b001, 32'h0F0F_0F0F, 4'b0010, 12'h455},
    {3'b010, 32'h0000_0000, 4'b1000, 12'h566},
    {3'b011, 32'h7777_7777, 4'b0001, 12'h677},
    {3'b110, 32'h8000_0001, 4'b0100, 12'h788},
    {3'b111, 32'h0101_0101, 4'b1001, 12'h899},
    {3'b101, 32'h0000_0000, 4'b0000, 12'h9AA},
    {3'b000, 32'hFFFF_FFFF, 4'b1000, 12'hABB},
    {3'b101, 32'h8000_0000, 4'b1001, 12'hFFF}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        mode_i = 3'b100;
  logic              rd_valid_i = 1'b0;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic [NB-1:0]     rd_par_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic              mem_wb_i = 1'b0;
  logic              mem_wb_o, event_o, abort_o, hold_o;
  logic              inval_req_o, refill_req_o;
  logic              inval_ack_i = 1'b0, refill_ack_i = 1'b0;
  logic [ADDR_W-1:0] fault_addr_o, recov_addr_o;

  int checks = 0;
  int failures = 0;
  logic [ADDR_W-1:0] exp_fault = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cache_parity_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cache_parity_ctrl (.*);

  function automatic logic [NB-1:0] even_par(logic [DATA_W-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // completes invalidate then refill with slow acknowledges
  task automatic recover(logic [ADDR_W-1:0] addr);
    repeat (2) @(negedge clk_i);
    check("R8 inval held", {31'b0, inval_req_o}, 1);
    check("R8 inval addr", {20'b0, recov_addr_o}, {20'b0, addr});
    check("R9 no early refill", {31'b0, refill_req_o}, 0);
    inval_ack_i = 1'b1;
    @(negedge clk_i);
    inval_ack_i = 1'b0;
    check("R9 refill after inval", {30'b0, refill_req_o, inval_req_o}, 2);
    check("R9 refill addr", {20'b0, recov_addr_o}, {20'b0, addr});
    @(negedge clk_i);
    check("R9 refill held", {31'b0, refill_req_o}, 1);
    check("R10 hold during refill", {31'b0, hold_o}, 1);
    refill_ack_i = 1'b1;
    @(negedge clk_i);
    refill_ack_i = 1'b0;
    check("R10 hold released", {30'b0, hold_o, refill_req_o}, 0);
  endtask

  task automatic do_read(logic [2:0] m, logic [DATA_W-1:0] d, logic [NB-1:0] mask,
                         logic [ADDR_W-1:0] a);
    logic chk, err, abt;
    chk = (m == 3'b000) || (m == 3'b101);
    err = chk && (mask != 0);
    abt = err && (m == 3'b000);
    mode_i = m; rd_data_i = d; rd_par_i = even_par(d) ^ mask; rd_addr_i = a;
    rd_valid_i = 1'b1;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    if (err) exp_fault = a;
    // R4 R1 R2 R3 R6
    check("R4 event", {31'b0, event_o}, {31'b0, err});
    check("R1 R2 abort", {31'b0, abort_o}, {31'b0, abt});
    check("R7 fault addr", {20'b0, fault_addr_o}, {20'b0, exp_fault});
    check("R3 recovery start", {30'b0, hold_o, inval_req_o}, {30'b0, err, err});
    @(negedge clk_i);
    check("R6 pulse ends", {30'b0, event_o, abort_o}, 0);
    if (err) recover(a);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 reset outputs", {27'b0, event_o, abort_o, hold_o, inval_req_o, refill_req_o}, 0);
    check("R11 reset fault addr", {20'b0, fault_addr_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++)
      do_read(VEC[i][50:48], VEC[i][47:16], VEC[i][15:12], VEC[i][11:0]);

    // R5 write-back forcing across every mode
    for (int m = 0; m < 8; m++) begin
      mode_i = m[2:0];
      mem_wb_i = 1'b1;
      #1;
      check("R5 wb attribute", {31'b0, mem_wb_o},
            {31'b0, !((m == 0) || (m == 5))});
      mem_wb_i = 1'b0;
      #1;
      check("R5 wb off", {31'b0, mem_wb_o}, 0);
    end

    // R10 faulty read during a stalled recovery is not checked
    @(negedge clk_i);
    mode_i = 3'b000; rd_data_i = 32'h5555_AAAA;
    rd_par_i = even_par(32'h5555_AAAA) ^ 4'b0010; rd_addr_i = 12'h3C3;
    rd_valid_i = 1'b1;
    @(negedge clk_i);
    exp_fault = 12'h3C3;
    check("R1 event on error", {30'b0, event_o, abort_o}, 3);
    rd_addr_i = 12'h777; rd_par_i = even_par(32'h5555_AAAA) ^ 4'b1000;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    check("R10 no event while held", {30'b0, event_o, abort_o}, 0);
    @(negedge clk_i);
    check("R10 fault addr kept", {20'b0, fault_addr_o}, {20'b0, exp_fault});
    check("R10 recovery addr kept", {20'b0, recov_addr_o}, 12'h3C3);
    recover(12'h3C3);

    // R7 clean read leaves fault address
    do_read(3'b101, 32'h1357_9BDF, 4'b0000, 12'h001);
    check("R7 fault addr stays", {20'b0, fault_addr_o}, 12'h3C3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule